// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Block

This block collects 64 level-sensitive interrupt sources and presents them to a processor on two request lines. Each source is marked as either normal or fast. The fast line is raised whenever any enabled, pending fast source exists. The normal line is additionally gated by a 5-bit threshold mask that is compared against a 4-bit priority held for every source.

Software reaches the state through a single-cycle, word-addressed register port. A read returns data one cycle after the read strobe. Enable bits can be set or cleared one at a time by writing a source number, or loaded 32 bits at a time. Two vector registers report the winning normal source and the winning fast source. Reading either one acknowledges that source by clearing its pending bit in the same cycle. A pair of force registers overwrites the pending state directly. A source input that stays high sets its pending bit again on the cycle after an acknowledge. A falling edge on a source input clears its pending bit.

The register map assumes the default sizes: 64 sources, a 32-bit data word, 4-bit priorities and a 5-bit mask.

Top module: `vic_regblock`

## Requirements
- R1: Synchronous active-high reset clears pending, enable, type, control and all priorities, sets the mask to 0x1F, and leaves both request lines low. A normal-vector read after reset returns 0xFFFFFFFF.
- R2: A write to word 2 sets the enable bit whose number is wdata[5:0]. Words 2 and 3 read as zero. Read data appears on rdata the cycle after the read strobe.
- R3: A write to word 3 clears the enable bit whose number is wdata[5:0].
- R4: Word 4 and word 5 load and return enable bits 63..32 and 31..0. Word 6 and word 7 do the same for the type bits, where 1 means fast.
- R5: The fast line is high exactly when some source is pending, enabled and typed fast.
- R6: When the mask is 0x1F, the normal line is high exactly when some source is pending, enabled and typed normal.
- R7: When the mask is below 0x1F, the normal line is high only if such a normal source has a priority strictly above the mask. Word 1 stores and returns wdata[4:0].
- R8: Word offset 8+m holds priority word 7-m. Priority word k covers sources 8k..8k+7, with source 8k+j in bits [4j+3:4j]. These words read back as written.
- R9: A read of word 16 returns the source number in bits [31:16] and its priority in bits [15:0] for the highest-priority pending, enabled normal source. Ties go to the higher source number. The read clears that source's pending bit. If no source qualifies, the read returns 0xFFFFFFFF.
- R10: A read of word 17 returns the lowest-numbered pending, enabled fast source and clears its pending bit. If no source qualifies, the read returns 0xFFFFFFFF.
- R11: Writes to word 20 and word 21 overwrite pending bits 63..32 and 31..0, and both words read as zero. Word 18 and word 19 return pending bits 63..32 and 31..0.
- R12: Words 22/23 return pending AND enabled AND normal (high/low). Words 24/25 return pending AND enabled AND fast. Writes to words 16-19 and 22-25, and to unmapped words, change no state. Unmapped words read as zero.
- R13: A write to word 0 keeps only bits 24, 22, 21, 20, 19 and 18 (mask 0x017C0000), and word 0 returns that value.
- R14: A high source input sets its pending bit on each clock. It sets the bit again on the cycle after an acknowledge or force clears it. A source input that falls from high to low clears its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Level-sensitive source inputs |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| irq_normal_o | output | 1 | Normal interrupt request |
| irq_fast_o | output | 1 | Fast interrupt request |

## Verification
The arbitration is tried with forced pending sets in which priorities are distinct, tied, or zero. These cases tell the highest-priority choice apart from a lowest-number or first-found choice, and they expose which way ties break. The threshold gate is probed with a priority equal to the mask, one above it, and a mask of 0x1F. This separates a strict compare from a greater-or-equal compare and from the bypass case. A held-high source is acknowledged and then read back on the next two cycles, which shows the clear followed by the re-set. A long random phase mixes source toggles with all register accesses, and the reference model is compared on every clock.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
  localparam int ADDR_W = 5;

  // word offsets of the register map
  localparam logic [ADDR_W-1:0] W_CTRL     = 5'd0;
  localparam logic [ADDR_W-1:0] W_MASK     = 5'd1;
  localparam logic [ADDR_W-1:0] W_ENNUM    = 5'd2;
  localparam logic [ADDR_W-1:0] W_DISNUM   = 5'd3;
  localparam logic [ADDR_W-1:0] W_EN_HI    = 5'd4;
  localparam logic [ADDR_W-1:0] W_EN_LO    = 5'd5;
  localparam logic [ADDR_W-1:0] W_TYPE_HI  = 5'd6;
  localparam logic [ADDR_W-1:0] W_TYPE_LO  = 5'd7;
  localparam logic [ADDR_W-1:0] W_PRIO_LO  = 5'd8;
  localparam logic [ADDR_W-1:0] W_PRIO_HI  = 5'd15;
  localparam logic [ADDR_W-1:0] W_NVEC     = 5'd16;
  localparam logic [ADDR_W-1:0] W_FVEC     = 5'd17;
  localparam logic [ADDR_W-1:0] W_SRC_HI   = 5'd18;
  localparam logic [ADDR_W-1:0] W_SRC_LO   = 5'd19;
  localparam logic [ADDR_W-1:0] W_FORCE_HI = 5'd20;
  localparam logic [ADDR_W-1:0] W_FORCE_LO = 5'd21;
  localparam logic [ADDR_W-1:0] W_NPEND_HI = 5'd22;
  localparam logic [ADDR_W-1:0] W_NPEND_LO = 5'd23;
  localparam logic [ADDR_W-1:0] W_FPEND_HI = 5'd24;
  localparam logic [ADDR_W-1:0] W_FPEND_LO = 5'd25;

  localparam logic [31:0] CTRL_KEEP = 32'h017C_0000;
  localparam logic [31:0] NO_WINNER = 32'hFFFF_FFFF;
endpackage

// File: rtl/vic_prio_store.sv
`timescale 1ns/1ps
module vic_prio_store #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en_i,
  input  logic [$clog2(NUM_SRC/(DATA_W/PRIO_W))-1:0] sel_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic [NUM_SRC*PRIO_W-1:0]   prio_flat_o
);
  localparam int PER_WORD   = DATA_W / PRIO_W;
  localparam int PRIO_WORDS = NUM_SRC / PER_WORD;

  logic [DATA_W-1:0] words_q [PRIO_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < PRIO_WORDS; k++) words_q[k] <= '0;
    end else if (wr_en_i) begin
      words_q[sel_i] <= wdata_i;
    end
  end

  assign rd_data_o = words_q[sel_i];

  // word k carries sources PER_WORD*k .. PER_WORD*k+PER_WORD-1
  for (genvar k = 0; k < PRIO_WORDS; k++) begin : g_flat
    assign prio_flat_o[k*DATA_W +: DATA_W] = words_q[k];
  end
endmodule

// File: rtl/vic_arbiter.sv
`timescale 1ns/1ps
module vic_arbiter #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_SRC-1:0]          norm_flags_i,
  input  logic [NUM_SRC-1:0]          fast_flags_i,
  input  logic [NUM_SRC*PRIO_W-1:0]   prio_flat_i,
  output logic                        n_valid_o,
  output logic [$clog2(NUM_SRC)-1:0]  n_idx_o,
  output logic [PRIO_W-1:0]           n_prio_o,
  output logic                        f_valid_o,
  output logic [$clog2(NUM_SRC)-1:0]  f_idx_o
);
  localparam int SRC_IDX_W = $clog2(NUM_SRC);

  // normal: highest priority, ties resolved toward the higher number
  always_comb begin
    n_valid_o = 1'b0;
    n_idx_o   = '0;
    n_prio_o  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (norm_flags_i[i] &&
          (!n_valid_o || prio_flat_i[i*PRIO_W +: PRIO_W] >= n_prio_o)) begin
        n_valid_o = 1'b1;
        n_idx_o   = SRC_IDX_W'(i);
        n_prio_o  = prio_flat_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  // fast: lowest numbered candidate
  always_comb begin
    f_valid_o = |fast_flags_i;
    f_idx_o   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (fast_flags_i[i]) f_idx_o = SRC_IDX_W'(i);
    end
  end

  logic [NUM_SRC-1:0] below_fast;
  assign below_fast = (NUM_SRC'(1) << f_idx_o) - NUM_SRC'(1);

  // R9: the reported normal winner is itself a candidate
  a_r9_winner_is_candidate: assert property (@(posedge clk) disable iff (rst)
    n_valid_o |-> norm_flags_i[n_idx_o])
    else $error("normal winner is not a candidate");

  // R10: fast winner is a candidate with no lower-numbered candidate
  a_r10_fast_lowest: assert property (@(posedge clk) disable iff (rst)
    f_valid_o |-> (fast_flags_i[f_idx_o] && ((fast_flags_i & below_fast) == '0)))
    else $error("fast winner is not the lowest candidate");
endmodule

// File: rtl/vic_req_gen.sv
`timescale 1ns/1ps
module vic_req_gen #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4,
  parameter int MASK_W  = 5
) (
  input  logic [NUM_SRC-1:0]        norm_flags_i,
  input  logic [NUM_SRC-1:0]        fast_flags_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat_i,
  input  logic [MASK_W-1:0]         mask_i,
  output logic                      irq_normal_o,
  output logic                      irq_fast_o
);
  logic [NUM_SRC-1:0] above;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
    assign above[i] = norm_flags_i[i] &&
                      (MASK_W'(prio_flat_i[i*PRIO_W +: PRIO_W]) > mask_i);
  end

  // an all-ones mask bypasses the threshold
  assign irq_normal_o = (&mask_i) ? (|norm_flags_i) : (|above);
  assign irq_fast_o   = |fast_flags_i;
endmodule

// File: rtl/vic_regblock.sv
`timescale 1ns/1ps
module vic_regblock
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int DATA_W  = 32,
  parameter int PRIO_W  = 4,
  parameter int MASK_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_normal_o,
  output logic               irq_fast_o
);
  localparam int SRC_IDX_W   = $clog2(NUM_SRC);
  localparam int HALF        = NUM_SRC / 2;
  localparam int PER_WORD    = DATA_W / PRIO_W;
  localparam int PRIO_WORDS  = NUM_SRC / PER_WORD;
  localparam int PWORD_IDX_W = $clog2(PRIO_WORDS);
  localparam int FIELD_W     = DATA_W / 2;

  logic [NUM_SRC-1:0] pend_q, en_q, fast_q, src_q;
  logic [NUM_SRC-1:0] pend_d, en_d, fast_d, ack_clr;
  logic [NUM_SRC-1:0] live, norm_flags, fast_flags;
  logic [DATA_W-1:0]  ctrl_q;
  logic [MASK_W-1:0]  mask_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic                 n_valid, f_valid;
  logic [SRC_IDX_W-1:0] n_idx, f_idx;
  logic [PRIO_W-1:0]    n_prio;
  logic                   wr_prio;
  logic [PWORD_IDX_W-1:0] prio_sel;
  logic [DATA_W-1:0]      prio_rd, rd_mux;

  assign live       = pend_q & en_q;
  assign norm_flags = live & ~fast_q;
  assign fast_flags = live & fast_q;

  assign wr_prio  = wr_en_i && (addr_i >= W_PRIO_LO) && (addr_i <= W_PRIO_HI);
  assign prio_sel = PWORD_IDX_W'(W_PRIO_HI - addr_i);

  vic_prio_store #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_prio (
    .clk         (clk),
    .rst         (rst),
    .wr_en_i     (wr_prio),
    .sel_i       (prio_sel),
    .wdata_i     (wdata_i),
    .rd_data_o   (prio_rd),
    .prio_flat_o (prio_flat)
  );

  vic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .clk          (clk),
    .rst          (rst),
    .norm_flags_i (norm_flags),
    .fast_flags_i (fast_flags),
    .prio_flat_i  (prio_flat),
    .n_valid_o    (n_valid),
    .n_idx_o      (n_idx),
    .n_prio_o     (n_prio),
    .f_valid_o    (f_valid),
    .f_idx_o      (f_idx)
  );

  vic_req_gen #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .MASK_W(MASK_W)) u_req (
    .norm_flags_i (norm_flags),
    .fast_flags_i (fast_flags),
    .prio_flat_i  (prio_flat),
    .mask_i       (mask_q),
    .irq_normal_o (irq_normal_o),
    .irq_fast_o   (irq_fast_o)
  );

  // acknowledge: a vector read clears its winner
  always_comb begin
    ack_clr = '0;
    if (rd_en_i && addr_i == W_NVEC && n_valid) ack_clr[n_idx] = 1'b1;
    if (rd_en_i && addr_i == W_FVEC && f_valid) ack_clr[f_idx] = 1'b1;
  end

  // pending: set by high level, cleared by falling level or acknowledge,
  // overwritten by a force write
  always_comb begin
    pend_d = (src_i | (pend_q & ~src_q)) & ~ack_clr;
    if (wr_en_i && addr_i == W_FORCE_HI) pend_d[NUM_SRC-1:HALF] = wdata_i;
    if (wr_en_i && addr_i == W_FORCE_LO) pend_d[HALF-1:0]       = wdata_i;
  end

  always_comb begin
    en_d = en_q;
    if (wr_en_i) begin
      case (addr_i)
        W_ENNUM:  en_d[wdata_i[SRC_IDX_W-1:0]] = 1'b1;
        W_DISNUM: en_d[wdata_i[SRC_IDX_W-1:0]] = 1'b0;
        W_EN_HI:  en_d[NUM_SRC-1:HALF] = wdata_i;
        W_EN_LO:  en_d[HALF-1:0]       = wdata_i;
        default:  en_d = en_q;
      endcase
    end
  end

  always_comb begin
    fast_d = fast_q;
    if (wr_en_i && addr_i == W_TYPE_HI) fast_d[NUM_SRC-1:HALF] = wdata_i;
    if (wr_en_i && addr_i == W_TYPE_LO) fast_d[HALF-1:0]       = wdata_i;
  end

  always_comb begin
    case (addr_i)
      W_CTRL:     rd_mux = ctrl_q;
      W_MASK:     rd_mux = DATA_W'(mask_q);
      W_EN_HI:    rd_mux = en_q[NUM_SRC-1:HALF];
      W_EN_LO:    rd_mux = en_q[HALF-1:0];
      W_TYPE_HI:  rd_mux = fast_q[NUM_SRC-1:HALF];
      W_TYPE_LO:  rd_mux = fast_q[HALF-1:0];
      W_NVEC:     rd_mux = n_valid ? {FIELD_W'(n_idx), FIELD_W'(n_prio)} : NO_WINNER;
      W_FVEC:     rd_mux = f_valid ? DATA_W'(f_idx) : NO_WINNER;
      W_SRC_HI:   rd_mux = pend_q[NUM_SRC-1:HALF];
      W_SRC_LO:   rd_mux = pend_q[HALF-1:0];
      W_NPEND_HI: rd_mux = norm_flags[NUM_SRC-1:HALF];
      W_NPEND_LO: rd_mux = norm_flags[HALF-1:0];
      W_FPEND_HI: rd_mux = fast_flags[NUM_SRC-1:HALF];
      W_FPEND_LO: rd_mux = fast_flags[HALF-1:0];
      default:    rd_mux = wr_prio_range(addr_i) ? prio_rd : '0;
    endcase
  end

  function automatic logic wr_prio_range(input logic [ADDR_W-1:0] a);
    return (a >= W_PRIO_LO) && (a <= W_PRIO_HI);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      en_q    <= '0;
      fast_q  <= '0;
      src_q   <= '0;
      ctrl_q  <= '0;
      mask_q  <= '1;
      rdata_o <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      fast_q <= fast_d;
      src_q  <= src_i;
      if (wr_en_i && addr_i == W_CTRL) ctrl_q <= wdata_i & CTRL_KEEP;
      if (wr_en_i && addr_i == W_MASK) mask_q <= wdata_i[MASK_W-1:0];
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end

  // R1: state left by reset
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (mask_q == '1 && pend_q == '0 && en_q == '0 && fast_q == '0))
    else $error("reset state wrong");

  // R2: enable by number sets the addressed bit
  a_r2_enable_by_number: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == W_ENNUM) |=> en_q[$past(wdata_i[SRC_IDX_W-1:0])])
    else $error("enable by number failed");

  // R2: number registers read as zero
  a_r2_number_regs_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && (addr_i == W_ENNUM || addr_i == W_DISNUM)) |=> (rdata_o == '0))
    else $error("number register read not zero");

  // R3: disable by number clears the addressed bit
  a_r3_disable_by_number: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == W_DISNUM) |=> !en_q[$past(wdata_i[SRC_IDX_W-1:0])])
    else $error("disable by number failed");

  // R9: normal vector read acknowledges its winner
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !wr_en_i && addr_i == W_NVEC && n_valid) |=> !pend_q[$past(n_idx)])
    else $error("normal acknowledge did not clear");

  // R10: fast vector read acknowledges its winner
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !wr_en_i && addr_i == W_FVEC && f_valid) |=> !pend_q[$past(f_idx)])
    else $error("fast acknowledge did not clear");
endmodule

// File: tb/vic_regblock_tb.sv
`timescale 1ns/1ps
module vic_regblock_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_n, irq_f;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  vic_regblock dut_i (
    .clk(clk), .rst(rst), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_normal_o(irq_n), .irq_fast_o(irq_f)
  );

  // behavioural reference state
  logic [63:0] m_pend, m_en, m_type, m_src_q, src_v;
  int          m_prio[64];
  int          m_mask;
  logic [31:0] m_ctrl, m_rdata;

  task automatic m_reset();
    m_pend = '0; m_en = '0; m_type = '0; m_src_q = '0;
    m_mask = 31; m_ctrl = '0; m_rdata = '0;
    for (int i = 0; i < 64; i++) m_prio[i] = 0;
  endtask

  function automatic bit m_fast();
    return |(m_pend & m_en & m_type);
  endfunction

  function automatic bit m_norm();
    bit any = 0, hi = 0;
    for (int i = 0; i < 64; i++)
      if (m_pend[i] && m_en[i] && !m_type[i]) begin
        any = 1;
        if (m_prio[i] > m_mask) hi = 1;
      end
    return (m_mask == 31) ? any : hi;
  endfunction

  function automatic logic [31:0] m_read(input int a, output int ack);
    logic [63:0] nf, ff;
    logic [31:0] v;
    int best, idx;
    ack = -1;
    nf = m_pend & m_en & ~m_type;
    ff = m_pend & m_en & m_type;
    v = 0;
    case (a)
      0: v = m_ctrl;
      1: v = m_mask;
      4: v = m_en[63:32];
      5: v = m_en[31:0];
      6: v = m_type[63:32];
      7: v = m_type[31:0];
      16: begin
        best = -1; idx = -1;
        for (int i = 0; i < 64; i++)
          if (nf[i] && m_prio[i] >= best) begin best = m_prio[i]; idx = i; end
        if (idx < 0) v = 32'hFFFF_FFFF;
        else begin v = {idx[15:0], best[15:0]}; ack = idx; end
      end
      17: begin
        idx = -1;
        for (int i = 63; i >= 0; i--) if (ff[i]) idx = i;
        if (idx < 0) v = 32'hFFFF_FFFF;
        else begin v = idx; ack = idx; end
      end
      18: v = m_pend[63:32];
      19: v = m_pend[31:0];
      22: v = nf[63:32];
      23: v = nf[31:0];
      24: v = ff[63:32];
      25: v = ff[31:0];
      default: begin
        if (a >= 8 && a <= 15)
          for (int j = 0; j < 8; j++) v[4*j +: 4] = m_prio[(15 - a) * 8 + j][3:0];
      end
    endcase
    return v;
  endfunction

  function automatic string tag_of(input int a);
    if (a == 0) return "R13";
    if (a == 1) return "R7";
    if (a == 2 || a == 3) return "R2";
    if (a >= 4 && a <= 7) return "R4";
    if (a >= 8 && a <= 15) return "R8";
    if (a == 16) return "R9";
    if (a == 17) return "R10";
    if (a >= 18 && a <= 21) return "R11";
    return "R12";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model, compare at next negedge
  task automatic step(input bit w, input bit r, input int a, input logic [31:0] d,
                      input string tag);
    logic [31:0] exp_rd;
    logic [63:0] np;
    int ack;
    wr_en = w; rd_en = r; addr = a[4:0]; wdata = d; src = src_v;
    ack = -1;
    exp_rd = m_rdata;
    if (r) exp_rd = m_read(a, ack);
    np = src_v | (m_pend & ~m_src_q);
    if (ack >= 0) np[ack] = 1'b0;
    if (w) begin
      case (a)
        0: m_ctrl = d & 32'h017C_0000;
        1: m_mask = int'(d[4:0]);
        2: m_en[d[5:0]] = 1'b1;
        3: m_en[d[5:0]] = 1'b0;
        4: m_en[63:32] = d;
        5: m_en[31:0] = d;
        6: m_type[63:32] = d;
        7: m_type[31:0] = d;
        20: np[63:32] = d;
        21: np[31:0] = d;
        default: begin
          if (a >= 8 && a <= 15)
            for (int j = 0; j < 8; j++) m_prio[(15 - a) * 8 + j] = int'(d[4*j +: 4]);
        end
      endcase
    end
    m_pend = np; m_src_q = src_v; m_rdata = exp_rd;
    @(posedge clk);
    @(negedge clk);
    if (r) check((tag == "") ? tag_of(a) : tag, rdata, exp_rd);
    check("R5", {31'b0, irq_f}, {31'b0, m_fast()});
    check((m_mask == 31) ? "R6" : "R7", {31'b0, irq_n}, {31'b0, m_norm()});
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    step(1, 0, a, d, "");
  endtask
  task automatic rd(input int a, input string tag);
    step(0, 1, a, 32'h0, tag);
  endtask
  task automatic idle();
    step(0, 0, 0, 32'h0, "");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    src_v = '0;
    m_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    check("R1", {30'b0, irq_n, irq_f}, 32'h0);
    rd(1, "R1");
    for (int a = 0; a < 20; a++) if (a != 2 && a != 3) rd(a, "R1");

    // R2 / R3: enable and disable by number
    wr(2, 32'h0000_00C5);
    rd(5, "R2");
    rd(2, "R2");
    wr(2, 32'd40);
    rd(4, "R2");
    wr(3, 32'd5);
    rd(5, "R3");
    rd(3, "R3");

    // R4: bulk enable and type
    wr(4, 32'hA5A5_0F0F); wr(5, 32'h1234_5678);
    rd(4, "R4"); rd(5, "R4");
    wr(6, 32'h8000_0001); wr(7, 32'h0000_00F0);
    rd(6, "R4"); rd(7, "R4");

    // R8: priority words
    for (int a = 8; a < 16; a++) wr(a, 32'h1357_9BDF ^ (a * 32'h0101_0101));
    for (int a = 8; a < 16; a++) rd(a, "R8");
    wr(8, 32'h7654_3210);   // sources 56..63
    wr(10, 32'h0000_0009);  // source 40 prio 9
    wr(15, 32'h0000_0300);  // source 2 prio 3
    for (int a = 9; a < 15; a++) if (a != 10) wr(a, 32'h0);
    rd(8, "R8"); rd(15, "R8");

    // setup: all enabled, sources 4..7 fast
    wr(4, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF);
    wr(6, 32'h0); wr(7, 32'h0000_00F0);

    // R5: fast line from a held source, R14 falling edge clears
    src_v = 64'h40; idle(); idle();
    rd(25, "R5");
    src_v = '0; idle();
    rd(19, "R14");

    // R6 then R7: threshold gating
    src_v = 64'h1 << 41; idle(); idle();
    wr(1, 32'd8); idle();
    src_v = (64'h1 << 41) | (64'h1 << 40); idle();
    wr(1, 32'd9); idle();
    wr(1, 32'd0); src_v = 64'h1 << 41; idle();
    wr(1, 32'hFF);
    rd(1, "R7");
    src_v = '0; idle();

    // R9: normal vector order and acknowledge
    wr(21, 32'h0000_0044);
    wr(20, 32'h8000_0300);
    for (int n = 0; n < 5; n++) rd(16, "R9");
    wr(10, 32'h0000_5509);
    wr(20, 32'h0000_0C00);
    rd(16, "R9"); rd(16, "R9"); rd(16, "R9");

    // R10: fast vector lowest first
    wr(21, 32'h0000_00F4);
    for (int n = 0; n < 5; n++) rd(17, "R10");

    // R11: force and source status
    wr(20, 32'hDEAD_BEEF); wr(21, 32'h0BAD_F00D);
    rd(18, "R11"); rd(19, "R11"); rd(20, "R11"); rd(21, "R11");

    // R12: read-only words and unmapped words ignore writes
    for (int a = 16; a < 32; a++) if (a < 20 || a > 21) wr(a, 32'h5A5A_A5A5);
    for (int a = 18; a < 28; a++) if (a < 20 || a > 21) rd(a, "R12");
    rd(4, "R12"); rd(5, "R12");

    // R13: control keeps only its defined bits
    wr(0, 32'hFFFF_FFFF);
    rd(0, "R13");

    // R14: held source sets again after acknowledge
    src_v = 64'h1 << 45; idle();
    wr(20, 32'h0); wr(21, 32'h0);
    rd(16, "R14");
    rd(18, "R14");
    rd(18, "R14");
    src_v = '0; idle();

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int a;
      logic [31:0] d;
      if (n % 8 == 0)
        src_v = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      a = $urandom_range(0, 27);
      d = (a == 1) ? $urandom_range(0, 31) : $urandom;
      if ($urandom_range(0, 1) == 0) step(1, 0, a, d, "");
      else step(0, 1, a, 32'h0, "");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule